// File: doc/BRIEF.md
# LCD Raster Timing Generator

This block produces the scan timing for a raster LCD panel from three packed 32-bit timing words. It runs on the pixel clock and steps a pixel counter through each line and a line counter through each frame. From the two counters it drives horizontal and vertical sync pulses, a data-enable strobe and a one-clock frame-start pulse. Each of the three outputs has its own polarity bit. The current pixel and line positions are also available as outputs.

The horizontal word gives the active width in groups of 16 pixels, plus the front porch, sync width and back porch. The vertical word gives the active line count, the sync width and two porch counts. The third word supplies the polarity bits. A dual-panel input halves the scanned active height, because the upper and lower halves of the glass are refreshed at the same time. The timing words are captured into shadow registers. A running frame is therefore never disturbed: new settings apply from the next frame start. Clearing `enable` parks the generator at pixel 0 of line 0 with all outputs at their idle levels.

Top module: `lcd_raster_timing`

## Requirements
- R1: A line lasts A+F+S+B pixel clocks. A = 16*(htiming[7:2]+1) is the active width, F = htiming[23:16]+1 is the front porch, S = htiming[15:8]+1 is the sync width and B = htiming[31:24]+1 is the back porch. `pix_cnt` steps by one per clock from 0 to the last pixel of the line and then returns to 0.
- R2: Before polarity is applied, horizontal sync is asserted for the pixel positions A+F up to A+F+S-1, on every line of the frame.
- R3: A frame lasts L+VF+VS+VB lines. VF = vtiming[23:16] and VB = vtiming[31:24] are plain counts that may be zero. VS = vtiming[15:10]+1. `line_cnt` advances once, when `pix_cnt` wraps to 0, and returns to 0 after the last line.
- R4: Before polarity is applied, vertical sync is asserted for whole lines, from line L+VF up to line L+VF+VS-1.
- R5: With `dual_panel` low, L = vtiming[9:0]+1. With `dual_panel` high, L = floor(vtiming[9:0]/2)+1.
- R6: Before polarity is applied, data-enable is high exactly when `pix_cnt` < A and `line_cnt` < L.
- R7: Polarity is set in `ptiming`. Bit 12 inverts hsync, bit 11 inverts vsync and bit 14 inverts data-enable. A cleared bit gives an active-high output whose idle level is 0.
- R8: While the generator is running, `frame_start` is high for exactly one clock, at pixel 0 of line 0.
- R9: While `enable` is low, both counters read 0, `frame_start` is low, and hsync, vsync and data-enable sit at their idle levels. `enable` is sampled on a rising clock edge. When it is first seen high there, the next clock period shows pixel 0 of line 0, and counting starts from there.
- R10: While running, changes to `htiming`, `vtiming`, `ptiming` and `dual_panel` have no effect until the frame in progress ends. While stopped, the values are picked up continuously.
- R11: While `rst_n` is low, the counters are 0 and hsync, vsync, data-enable and `frame_start` are all 0, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| enable | input | 1 | Run control; low parks the scan |
| dual_panel | input | 1 | Halves the scanned active height |
| htiming | input | 32 | Horizontal timing word |
| vtiming | input | 32 | Vertical timing word |
| ptiming | input | 32 | Polarity word (bits 11, 12, 14 used) |
| hsync | output | 1 | Horizontal sync after polarity |
| vsync | output | 1 | Vertical sync after polarity |
| data_en | output | 1 | Data-enable after polarity |
| pix_cnt | output | H_W | Current pixel position in the line |
| line_cnt | output | V_W | Current line position in the frame |
| frame_start | output | 1 | One-clock pulse at pixel 0 of line 0 |

## Verification
All outputs come from registers through a little gating, so each result is due in the clock period that follows the edge that caused it. A rising edge that samples `enable` high shows pixel 0 of line 0 in the next period. A line-end wrap updates both counters in that same period. A frame end loads the new shadow settings together with the return to the origin. The bench mirrors this in a reference model that it advances once per rising edge. It queues one expected item per edge, and a monitor pops each item on the following falling edge. Every comparison therefore takes place mid-period, one register stage after the edge that produced the value. Settings changed in the middle of a frame are checked in the same way, and the model applies them only at the frame boundary.

// File: rtl/lcd_tg_pkg.sv
`timescale 1ns/1ps
package lcd_tg_pkg;
  // horizontal word field positions
  localparam int HACT_LSB  = 2;
  localparam int HACT_W    = 6;
  localparam int HSW_LSB   = 8;
  localparam int HFP_LSB   = 16;
  localparam int HBP_LSB   = 24;
  localparam int HFIELD_W  = 8;
  // active width unit is 2**PIX_GROUP_SHIFT pixels
  localparam int PIX_GROUP_SHIFT = 4;

  // vertical word field positions
  localparam int VACT_LSB  = 0;
  localparam int VACT_W    = 10;
  localparam int VSW_LSB   = 10;
  localparam int VSW_W     = 6;
  localparam int VFP_LSB   = 16;
  localparam int VBP_LSB   = 24;
  localparam int VFIELD_W  = 8;

  // polarity word bit positions
  localparam int INV_V_BIT  = 11;
  localparam int INV_H_BIT  = 12;
  localparam int INV_DE_BIT = 14;

  typedef struct packed {
    logic inv_de;
    logic inv_h;
    logic inv_v;
  } lcd_pol_t;
endpackage

// File: rtl/lcd_tg_shadow.sv
`timescale 1ns/1ps
module lcd_tg_shadow
  import lcd_tg_pkg::*;
#(
  parameter int H_W = 12,
  parameter int V_W = 11
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           dual,
  input  logic [31:0]    htim,
  input  logic [31:0]    vtim,
  input  logic [31:0]    ptim,
  output logic [H_W-1:0] h_act_end,
  output logic [H_W-1:0] h_sync_beg,
  output logic [H_W-1:0] h_sync_end,
  output logic [H_W-1:0] h_last,
  output logic [V_W-1:0] v_act_end,
  output logic [V_W-1:0] v_sync_beg,
  output logic [V_W-1:0] v_sync_end,
  output logic [V_W-1:0] v_last,
  output lcd_pol_t       pol
);
  logic [H_W-1:0] h_act_len, h_fp_len, h_sw_len, h_bp_len;
  logic [H_W-1:0] h_act_end_d, h_sync_beg_d, h_sync_end_d, h_last_d;
  logic [V_W-1:0] v_act_len, v_fp_len, v_sw_len, v_bp_len;
  logic [V_W-1:0] v_act_end_d, v_sync_beg_d, v_sync_end_d, v_last_d;
  logic [VACT_W-1:0] v_act_field;
  lcd_pol_t       pol_d;

  logic [H_W-1:0] h_act_end_q, h_sync_beg_q, h_sync_end_q, h_last_q;
  logic [V_W-1:0] v_act_end_q, v_sync_beg_q, v_sync_end_q, v_last_q;
  lcd_pol_t       pol_q;

  // Decode the packed words into region boundaries (next-state logic).
  always_comb begin
    h_act_len = (H_W'(htim[HACT_LSB +: HACT_W]) + H_W'(1)) << PIX_GROUP_SHIFT;
    h_fp_len  = H_W'(htim[HFP_LSB +: HFIELD_W]) + H_W'(1);
    h_sw_len  = H_W'(htim[HSW_LSB +: HFIELD_W]) + H_W'(1);
    h_bp_len  = H_W'(htim[HBP_LSB +: HFIELD_W]) + H_W'(1);

    h_act_end_d  = h_act_len;
    h_sync_beg_d = h_act_len + h_fp_len;
    h_sync_end_d = h_sync_beg_d + h_sw_len;
    h_last_d     = h_sync_end_d + h_bp_len - H_W'(1);

    v_act_field = vtim[VACT_LSB +: VACT_W];
    if (dual) begin
      v_act_len = V_W'(v_act_field >> 1) + V_W'(1);
    end else begin
      v_act_len = V_W'(v_act_field) + V_W'(1);
    end
    v_fp_len = V_W'(vtim[VFP_LSB +: VFIELD_W]);
    v_sw_len = V_W'(vtim[VSW_LSB +: VSW_W]) + V_W'(1);
    v_bp_len = V_W'(vtim[VBP_LSB +: VFIELD_W]);

    v_act_end_d  = v_act_len;
    v_sync_beg_d = v_act_len + v_fp_len;
    v_sync_end_d = v_sync_beg_d + v_sw_len;
    v_last_d     = v_sync_end_d + v_bp_len - V_W'(1);

    pol_d.inv_de = ptim[INV_DE_BIT];
    pol_d.inv_h  = ptim[INV_H_BIT];
    pol_d.inv_v  = ptim[INV_V_BIT];
  end

  // Shadow registers, clock-enabled by load.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_act_end_q  <= '0;
      h_sync_beg_q <= '0;
      h_sync_end_q <= '0;
      h_last_q     <= '0;
      v_act_end_q  <= '0;
      v_sync_beg_q <= '0;
      v_sync_end_q <= '0;
      v_last_q     <= '0;
      pol_q        <= '0;
    end else if (load) begin
      h_act_end_q  <= h_act_end_d;
      h_sync_beg_q <= h_sync_beg_d;
      h_sync_end_q <= h_sync_end_d;
      h_last_q     <= h_last_d;
      v_act_end_q  <= v_act_end_d;
      v_sync_beg_q <= v_sync_beg_d;
      v_sync_end_q <= v_sync_end_d;
      v_last_q     <= v_last_d;
      pol_q        <= pol_d;
    end
  end

  assign h_act_end  = h_act_end_q;
  assign h_sync_beg = h_sync_beg_q;
  assign h_sync_end = h_sync_end_q;
  assign h_last     = h_last_q;
  assign v_act_end  = v_act_end_q;
  assign v_sync_beg = v_sync_beg_q;
  assign v_sync_end = v_sync_end_q;
  assign v_last     = v_last_q;
  assign pol        = pol_q;

  // Bits of the words that carry no raster timing.
  logic unused_word_bits;
  assign unused_word_bits = ^{htim[1:0], ptim[31:INV_DE_BIT+1], ptim[INV_H_BIT+1],
                              ptim[INV_V_BIT-1:0]};
endmodule

// File: rtl/lcd_tg_axis.sv
`timescale 1ns/1ps
module lcd_tg_axis #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          step,
  input  logic [CW-1:0] act_end,
  input  logic [CW-1:0] sync_beg,
  input  logic [CW-1:0] sync_end,
  input  logic [CW-1:0] last,
  output logic [CW-1:0] cnt,
  output logic          wrap,
  output logic          in_act,
  output logic          in_sync
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    wrap   = step && (cnt_q == last);
    cnt_en = clear || step;
    if (clear || wrap) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
    in_act  = (cnt_q < act_end);
    in_sync = (cnt_q >= sync_beg) && (cnt_q < sync_end);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/lcd_raster_timing.sv
`timescale 1ns/1ps
module lcd_raster_timing
  import lcd_tg_pkg::*;
#(
  parameter int H_W             = 12,
  parameter int V_W             = 11,
  parameter int RST_SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           enable,
  input  logic           dual_panel,
  input  logic [31:0]    htiming,
  input  logic [31:0]    vtiming,
  input  logic [31:0]    ptiming,
  output logic           hsync,
  output logic           vsync,
  output logic           data_en,
  output logic [H_W-1:0] pix_cnt,
  output logic [V_W-1:0] line_cnt,
  output logic           frame_start
);
  // Reset: asserted asynchronously, released on the clock.
  logic [RST_SYNC_STAGES-1:0] rst_sync_q;
  logic                       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[RST_SYNC_STAGES-2:0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[RST_SYNC_STAGES-1];

  // Run flag: enable seen on the previous edge.
  logic run_q, run_d;

  logic [H_W-1:0] h_act_end, h_sync_beg, h_sync_end, h_last;
  logic [V_W-1:0] v_act_end, v_sync_beg, v_sync_end, v_last;
  lcd_pol_t       pol;

  logic           h_wrap, h_in_act, h_in_sync;
  logic           v_wrap, v_in_act, v_in_sync;
  logic           frame_end, shadow_load, cnt_clear, v_step;
  logic [H_W-1:0] h_cnt;
  logic [V_W-1:0] v_cnt;

  always_comb begin
    run_d       = enable;
    cnt_clear   = !enable;
    v_step      = h_wrap;
    frame_end   = enable && h_wrap && v_wrap;
    shadow_load = !run_q || !enable || frame_end;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      run_q <= 1'b0;
    end else begin
      run_q <= run_d;
    end
  end

  lcd_tg_shadow #(
    .H_W (H_W),
    .V_W (V_W)
  ) u_shadow (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .load       (shadow_load),
    .dual       (dual_panel),
    .htim       (htiming),
    .vtim       (vtiming),
    .ptim       (ptiming),
    .h_act_end  (h_act_end),
    .h_sync_beg (h_sync_beg),
    .h_sync_end (h_sync_end),
    .h_last     (h_last),
    .v_act_end  (v_act_end),
    .v_sync_beg (v_sync_beg),
    .v_sync_end (v_sync_end),
    .v_last     (v_last),
    .pol        (pol)
  );

  lcd_tg_axis #(
    .CW (H_W)
  ) u_h_axis (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .clear    (cnt_clear),
    .step     (run_q),
    .act_end  (h_act_end),
    .sync_beg (h_sync_beg),
    .sync_end (h_sync_end),
    .last     (h_last),
    .cnt      (h_cnt),
    .wrap     (h_wrap),
    .in_act   (h_in_act),
    .in_sync  (h_in_sync)
  );

  lcd_tg_axis #(
    .CW (V_W)
  ) u_v_axis (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .clear    (cnt_clear),
    .step     (v_step),
    .act_end  (v_act_end),
    .sync_beg (v_sync_beg),
    .sync_end (v_sync_end),
    .last     (v_last),
    .cnt      (v_cnt),
    .wrap     (v_wrap),
    .in_act   (v_in_act),
    .in_sync  (v_in_sync)
  );

  // Output stage: gate by run flag, then apply polarity.
  always_comb begin
    hsync       = (run_q && h_in_sync) ^ pol.inv_h;
    vsync       = (run_q && v_in_sync) ^ pol.inv_v;
    data_en     = (run_q && h_in_act && v_in_act) ^ pol.inv_de;
    frame_start = run_q && (h_cnt == '0) && (v_cnt == '0);
    pix_cnt     = h_cnt;
    line_cnt    = v_cnt;
  end
endmodule

// File: rtl/lcd_raster_timing_chk.sv
`timescale 1ns/1ps
module lcd_raster_timing_chk #(
  parameter int H_W = 12,
  parameter int V_W = 11
) (
  input logic           clk,
  input logic           rst_n,
  input logic           enable,
  input logic           vsync,
  input logic           frame_start,
  input logic [H_W-1:0] pix_cnt,
  input logic [V_W-1:0] line_cnt
);
  // R1
  pix_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_cnt != '0) |=> ((pix_cnt == '0) || (pix_cnt == $past(pix_cnt) + H_W'(1))));

  // R3
  line_at_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(line_cnt) |-> (pix_cnt == '0));

  // R4
  vsync_line_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vsync) |-> (pix_cnt == '0));

  // R8
  frame_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);

  // R9
  disabled_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> ((pix_cnt == '0) && (line_cnt == '0) && !frame_start));
endmodule

bind lcd_raster_timing lcd_raster_timing_chk #(
  .H_W (H_W),
  .V_W (V_W)
) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .enable      (enable),
  .vsync       (vsync),
  .frame_start (frame_start),
  .pix_cnt     (pix_cnt),
  .line_cnt    (line_cnt)
);

// File: tb/test_lcd_raster_timing.sv
`timescale 1ns/1ps
module test_lcd_raster_timing;
  localparam int H_W = 12;
  localparam int V_W = 11;

  logic           clk = 1'b0;
  logic           rst_n, enable, dual_panel;
  logic [31:0]    htiming, vtiming, ptiming;
  logic           hsync, vsync, data_en, frame_start;
  logic [H_W-1:0] pix_cnt;
  logic [V_W-1:0] line_cnt;

  always #2.5 clk = ~clk;

  lcd_raster_timing #(.H_W(H_W), .V_W(V_W)) i_lcd_raster_timing (
    .clk(clk), .rst_n(rst_n), .enable(enable), .dual_panel(dual_panel),
    .htiming(htiming), .vtiming(vtiming), .ptiming(ptiming),
    .hsync(hsync), .vsync(vsync), .data_en(data_en),
    .pix_cnt(pix_cnt), .line_cnt(line_cnt), .frame_start(frame_start)
  );

  typedef struct {
    int    pix;
    int    line;
    bit    hs;
    bit    vs;
    bit    de;
    bit    fs;
    string tag;
  } exp_t;

  exp_t  exp_q[$];
  int    n_vec = 0;
  int    n_bad = 0;
  bit    done  = 1'b0;
  string cur_tag = "R11";

  // reference model state
  bit m_run = 1'b0;
  int m_h = 0, m_v = 0;
  int s_act, s_hfp, s_hsw, s_hbp, s_lines, s_vfp, s_vsw, s_vbp;
  bit s_ih, s_iv, s_ide;

  function automatic void take_settings();
    s_act   = (int'(htiming[7:2]) + 1) * 16;
    s_hsw   = int'(htiming[15:8]) + 1;
    s_hfp   = int'(htiming[23:16]) + 1;
    s_hbp   = int'(htiming[31:24]) + 1;
    s_lines = dual_panel ? (int'(vtiming[9:0]) / 2 + 1) : (int'(vtiming[9:0]) + 1);
    s_vsw   = int'(vtiming[15:10]) + 1;
    s_vfp   = int'(vtiming[23:16]);
    s_vbp   = int'(vtiming[31:24]);
    s_iv    = ptiming[11];
    s_ih    = ptiming[12];
    s_ide   = ptiming[14];
  endfunction

  task automatic tick();
    int  htot, vtot;
    bit  fend;
    exp_t e;
    @(posedge clk);
    #1;
    htot = s_act + s_hfp + s_hsw + s_hbp;
    vtot = s_lines + s_vfp + s_vsw + s_vbp;
    fend = m_run && enable && (m_h == htot - 1) && (m_v == vtot - 1);
    if (!enable) begin
      m_h = 0;
      m_v = 0;
    end else if (m_run) begin
      if (m_h == htot - 1) begin
        m_h = 0;
        m_v = (m_v == vtot - 1) ? 0 : m_v + 1;
      end else begin
        m_h = m_h + 1;
      end
    end
    if (!m_run || !enable || fend) take_settings();
    m_run = enable;
    e.pix  = m_h;
    e.line = m_v;
    e.hs   = (m_run && m_h >= s_act + s_hfp && m_h < s_act + s_hfp + s_hsw) ^ s_ih;
    e.vs   = (m_run && m_v >= s_lines + s_vfp && m_v < s_lines + s_vfp + s_vsw) ^ s_iv;
    e.de   = (m_run && m_h < s_act && m_v < s_lines) ^ s_ide;
    e.fs   = m_run && m_h == 0 && m_v == 0;
    e.tag  = cur_tag;
    exp_q.push_back(e);
  endtask

  task automatic run(input int n);
    repeat (n) tick();
  endtask

  function automatic bit cmp(input string tag, input string what, input int got, input int exp);
    if (got != exp) begin
      $display("FAIL %s %s: got %0d expected %0d at %0t", tag, what, got, exp, $time);
      return 1'b0;
    end
    return 1'b1;
  endfunction

  // Monitor: one expected item per clock period, compared mid-period.
  always @(negedge clk) begin
    if (exp_q.size() != 0) begin
      exp_t e;
      bit   ok;
      e  = exp_q.pop_front();
      ok = 1'b1;
      ok &= cmp(e.tag, "pix_cnt(R1)",      int'(pix_cnt),     e.pix);
      ok &= cmp(e.tag, "line_cnt(R3)",     int'(line_cnt),    e.line);
      ok &= cmp(e.tag, "hsync(R2)",        int'(hsync),       int'(e.hs));
      ok &= cmp(e.tag, "vsync(R4)",        int'(vsync),       int'(e.vs));
      ok &= cmp(e.tag, "data_en(R6)",      int'(data_en),     int'(e.de));
      ok &= cmp(e.tag, "frame_start(R8)",  int'(frame_start), int'(e.fs));
      n_vec++;
      if (!ok) n_bad++;
    end
  end

  task automatic direct_check(input string tag, input string what, input int got, input int exp);
    n_vec++;
    if (!cmp(tag, what, got, exp)) n_bad++;
  endtask

  // Watchdog
  initial begin
    #100000;
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog: got no completion, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n      = 1'b0;
    enable     = 1'b0;
    dual_panel = 1'b0;
    htiming    = 32'h0101_0200;   // 16 active, fp 2, sync 3, bp 2 -> 23 clocks
    vtiming    = 32'h0101_0402;   // 3 lines, fp 1, sync 2, bp 1 -> 7 lines
    ptiming    = 32'h0000_5800;   // all inversions requested during reset

    // R11: reset state ignores the inversion bits on the inputs
    repeat (3) @(posedge clk);
    @(negedge clk);
    direct_check("R11", "pix_cnt",     int'(pix_cnt),     0);
    direct_check("R11", "line_cnt",    int'(line_cnt),    0);
    direct_check("R11", "hsync",       int'(hsync),       0);
    direct_check("R11", "vsync",       int'(vsync),       0);
    direct_check("R11", "data_en",     int'(data_en),     0);
    direct_check("R11", "frame_start", int'(frame_start), 0);

    ptiming = 32'h0;
    @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R9: parked while disabled
    cur_tag = "R9";
    run(5);

    // R1/R2/R3/R4/R6/R8: two frames plus a bit
    enable  = 1'b1;
    cur_tag = "R1";
    run(2 * 161 + 10);

    // R10: mid-frame change of width and polarity waits for the frame end
    htiming = 32'h0101_0204;      // 32 active -> 39 clocks
    ptiming = 32'h0000_5800;
    cur_tag = "R10";
    run(151 + 2 * 273 + 20);

    // R9: disable mid-frame with inverted polarity -> idle levels are high
    enable  = 1'b0;
    cur_tag = "R9";
    run(8);

    // R7: hsync inversion alone, then vsync inversion alone
    htiming = 32'h0101_0200;
    ptiming = 32'h0000_1000;
    run(1);
    enable  = 1'b1;
    cur_tag = "R7";
    run(200);
    enable  = 1'b0;
    run(2);
    ptiming = 32'h0000_0800;
    enable  = 1'b1;
    run(200);

    // R5: dual mode halves the active height (field 5 -> 3 lines, not 6)
    enable     = 1'b0;
    run(2);
    ptiming    = 32'h0;
    dual_panel = 1'b1;
    vtiming    = 32'h0101_0405;
    enable     = 1'b1;
    cur_tag    = "R5";
    run(330);

    // R3: zero vertical porches, one sync line, two active lines
    enable     = 1'b0;
    run(2);
    dual_panel = 1'b0;
    vtiming    = 32'h0000_0001;
    enable     = 1'b1;
    cur_tag    = "R3";
    run(23 * 3 * 2 + 5);

    wait (exp_q.size() == 0);
    @(negedge clk);
    #1;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule